// File: doc/BRIEF.md
# Quasi-Bidirectional General-Purpose I/O Port

This block models, at the logic level, an eight-pin general-purpose port of a small microcontroller. Every pin has one storage bit, written from the internal data bus when the write strobe is high. The stored bit controls a pull-down. A stored 0 sinks the pin to ground. A stored 1 releases the pin, so an external source or the optional internal pull-up sets its level. A pin needs no direction register. Software writes a 1 to release the pin and then reads back whatever level the outside world applies.

The CPU has two read paths. A pin read returns the resolved pin level after a two-flop synchronizer. A latch read returns the stored bits, which can differ from the pins when something outside holds a released pin low. Read-modify-write sequences use the latch read, so bits held low from outside are not copied back into the latch. A build parameter selects between two pin styles: one with an internal pull-up, and an open-drain style with no pull-up. In the open-drain style a released, undriven pin floats. It is flagged as high-impedance and shows X as its level.

Top module: `qbio_port`

## Requirements
- R1: After reset every latch bit is 1, so `pin_pd_n` is all ones and no pull-down is active. In the pull-up build with no external driver, `pin_level` reads all ones and a pin read returns 8'hFF.
- R2: On a clock edge with `wr_latch` high, the latch takes `bus_wdata`, and `pin_pd_n` shows the new value after that edge. Without `wr_latch` the latch holds, whatever `bus_wdata` does.
- R3: A pin whose latch bit is 0 has its pull-down active (`pin_pd_n` bit = 0), and its `pin_level` is 0 even if an external driver applies 1.
- R4: In the pull-up build a pin whose latch bit is 1 and that has no external driver reads 1. `pin_hiz` is always 0 in this build.
- R5: A pin whose latch bit is 1 and whose external driver is enabled (`ext_drive_en` bit = 1) takes the level on `ext_level`, high or low.
- R6: While `rd_pin` is high, `bus_rdata` returns `pin_level` as it was sampled two clock edges earlier. A change on a pin is not seen after one edge and is seen after two.
- R7: While `rd_latch` is high and `rd_pin` is low, `bus_rdata` returns the latch contents, even where a pin is held at another level.
- R8: With both read strobes high, the pin read wins. With neither high, `bus_rdata` is 8'h00.
- R9: In the open-drain build a pin whose latch bit is 1 and that has no external driver has `pin_hiz` = 1 and `pin_level` = X. A pin that is pulled down or driven from outside has `pin_hiz` = 0.
- R10: A read-modify-write done through the latch read (read latch, change bits, write back) leaves bits that are held low from outside at 1 in the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wdata | input | 8 | Data from the internal bus for a latch write |
| wr_latch | input | 1 | Write strobe: latch loads `bus_wdata` at the clock edge |
| rd_pin | input | 1 | Read strobe for the synchronized pin levels |
| rd_latch | input | 1 | Read strobe for the stored latch bits |
| ext_drive_en | input | 8 | Per pin: an external source is driving the pin |
| ext_level | input | 8 | Per pin: level applied by that external source |
| pin_pd_n | output | 8 | Per pin: active-low pull-down enable (0 = pin sunk to ground) |
| pin_level | output | 8 | Per pin: resolved pin level (X when floating) |
| pin_hiz | output | 8 | Per pin: nothing drives the pin (open-drain build only) |
| bus_rdata | output | 8 | Read data returned to the internal bus |

## Verification
A corrupted latch bit shows on `pin_pd_n` and on the latch read in the cycle after the write that should have set it. When the bit sinks a pin, it also forces `pin_level` low at once. A fault in the synchronizer chain, such as a missing or extra stage, moves the moment a pin change first appears on `bus_rdata` by one cycle. The bench therefore checks both the edge where the change is not yet visible and the edge where it is. A read path that takes the pin instead of the latch shows up as soon as one released pin is held low from outside and the other path is compared.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

    localparam int unsigned DEF_WIDTH       = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        RSRC_NONE  = 2'd0,
        RSRC_PIN   = 2'd1,
        RSRC_LATCH = 2'd2
    } rsrc_e;

    // pin read has priority over latch read
    function automatic rsrc_e pick_src(input logic want_pin, input logic want_latch);
        rsrc_e s;
        if (want_pin)
            s = RSRC_PIN;
        else if (want_latch)
            s = RSRC_LATCH;
        else
            s = RSRC_NONE;
        return s;
    endfunction

endpackage

// File: rtl/qbio_latch.sv
module qbio_latch #(
    parameter int unsigned WIDTH = qbio_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.bits = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.bits <= '1;
        else
            st_q <= st_d;
    end

    assign q = st_q.bits;

endmodule

// File: rtl/qbio_pad.sv
module qbio_pad #(
    parameter int unsigned WIDTH  = qbio_pkg::DEF_WIDTH,
    parameter bit          PULLUP = 1'b1
) (
    input  logic [WIDTH-1:0] latch_bits,
    input  logic [WIDTH-1:0] ext_en,
    input  logic [WIDTH-1:0] ext_lvl,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] hiz
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (PULLUP) begin : g_pu
            always_comb begin
                hiz[i] = 1'b0;
                if (!latch_bits[i])
                    level[i] = 1'b0;
                else if (ext_en[i])
                    level[i] = ext_lvl[i];
                else
                    level[i] = 1'b1;
            end
        end else begin : g_od
            always_comb begin
                hiz[i] = 1'b0;
                if (!latch_bits[i]) begin
                    level[i] = 1'b0;
                end else if (ext_en[i]) begin
                    level[i] = ext_lvl[i];
                end else begin
                    level[i] = 1'bx;
                    hiz[i]   = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
    parameter int unsigned WIDTH  = qbio_pkg::DEF_WIDTH,
    parameter int unsigned STAGES = qbio_pkg::DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.chain[0] = d;
        for (int i = 1; i < STAGES; i++)
            st_d.chain[i] = st_q.chain[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.chain <= '1;
        else
            st_q <= st_d;
    end

    assign q = st_q.chain[STAGES-1];

endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
    parameter int unsigned WIDTH       = qbio_pkg::DEF_WIDTH,
    parameter bit          PULLUP      = 1'b1,
    parameter int unsigned SYNC_STAGES = qbio_pkg::DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             wr_latch,
    input  logic             rd_pin,
    input  logic             rd_latch,
    input  logic [WIDTH-1:0] ext_drive_en,
    input  logic [WIDTH-1:0] ext_level,
    output logic [WIDTH-1:0] pin_pd_n,
    output logic [WIDTH-1:0] pin_level,
    output logic [WIDTH-1:0] pin_hiz,
    output logic [WIDTH-1:0] bus_rdata
);

    import qbio_pkg::*;

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_sync;
    rsrc_e            rsrc;

    qbio_latch #(.WIDTH(WIDTH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_latch),
        .wdata (bus_wdata),
        .q     (latch_q)
    );

    qbio_pad #(.WIDTH(WIDTH), .PULLUP(PULLUP)) u_pad (
        .latch_bits (latch_q),
        .ext_en     (ext_drive_en),
        .ext_lvl    (ext_level),
        .level      (pin_level),
        .hiz        (pin_hiz)
    );

    qbio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_level),
        .q     (pin_sync)
    );

    assign pin_pd_n = latch_q;

    always_comb begin
        rsrc = pick_src(rd_pin, rd_latch);
        case (rsrc)
            RSRC_PIN:   bus_rdata = pin_sync;
            RSRC_LATCH: bus_rdata = latch_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
    parameter int unsigned WIDTH       = 8,
    parameter bit          PULLUP      = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] bus_wdata,
    input logic             wr_latch,
    input logic             rd_pin,
    input logic             rd_latch,
    input logic [WIDTH-1:0] ext_drive_en,
    input logic [WIDTH-1:0] pin_pd_n,
    input logic [WIDTH-1:0] pin_level,
    input logic [WIDTH-1:0] pin_hiz,
    input logic [WIDTH-1:0] bus_rdata
);

    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            warm_q <= 2'd0;
        else if (warm_q != 2'd3)
            warm_q <= warm_q + 2'd1;
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd0) |-> (pin_pd_n == '1));

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch |=> (pin_pd_n == $past(bus_wdata)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_latch && warm_q != 2'd0) |=> $stable(pin_pd_n));

    p_pulldown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pin_pd_n) & pin_level) === '0);

    p_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hiz & (~pin_pd_n | ext_drive_en)) == '0);

    if (PULLUP) begin : g_pu_chk
        p_nofloat_r4: assert property (@(posedge clk) disable iff (!rst_n)
            pin_hiz == '0);
    end

    if (SYNC_STAGES == 2) begin : g_sync_chk
        p_pin_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_pin && warm_q >= 2'd2) |-> (bus_rdata === $past(pin_level, 2)));
    end

    p_latch_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latch && !rd_pin) |-> (bus_rdata == pin_pd_n));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_latch && !rd_pin) |-> (bus_rdata == '0));

endmodule

bind qbio_port qbio_port_chk #(
    .WIDTH       (WIDTH),
    .PULLUP      (PULLUP),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wdata    (bus_wdata),
    .wr_latch     (wr_latch),
    .rd_pin       (rd_pin),
    .rd_latch     (rd_latch),
    .ext_drive_en (ext_drive_en),
    .pin_pd_n     (pin_pd_n),
    .pin_level    (pin_level),
    .pin_hiz      (pin_hiz),
    .bus_rdata    (bus_rdata)
);

// File: tb/qbio_port_tb.sv
module qbio_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       wr_latch = 1'b0;
    logic       rd_pin = 1'b0;
    logic       rd_latch = 1'b0;
    logic [7:0] ext_drive_en = '0;
    logic [7:0] ext_level = '0;

    logic [7:0] pd_n, lvl, hiz, rdata;
    logic [7:0] od_pd_n, od_lvl, od_hiz, od_rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    qbio_port #(.PULLUP(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_latch(wr_latch),
        .rd_pin(rd_pin), .rd_latch(rd_latch), .ext_drive_en(ext_drive_en),
        .ext_level(ext_level), .pin_pd_n(pd_n), .pin_level(lvl),
        .pin_hiz(hiz), .bus_rdata(rdata)
    );

    qbio_port #(.PULLUP(1'b0)) u_dut_od (
        .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_latch(wr_latch),
        .rd_pin(rd_pin), .rd_latch(rd_latch), .ext_drive_en(ext_drive_en),
        .ext_level(ext_level), .pin_pd_n(od_pd_n), .pin_level(od_lvl),
        .pin_hiz(od_hiz), .bus_rdata(od_rdata)
    );

    typedef struct packed {
        logic [7:0] wdata;
        logic [7:0] en;
        logic [7:0] ext;
        logic [7:0] exp_lvl;
        logic [7:0] exp_odhiz;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF},
        '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00},
        '{8'hA5, 8'h00, 8'h00, 8'hA5, 8'hA5},
        '{8'hFF, 8'h0F, 8'h00, 8'hF0, 8'hF0},
        '{8'hF0, 8'hFF, 8'h3C, 8'h30, 8'h00},
        '{8'h5A, 8'hA0, 8'hA0, 8'h5A, 8'h5A}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wdata = d;
        wr_latch  = 1'b1;
        tick();
        wr_latch  = 1'b0;
    endtask

    task automatic read_pin(output logic [7:0] v);
        rd_pin = 1'b1; #2; v = rdata; rd_pin = 1'b0; #1;
    endtask

    task automatic read_latch(output logic [7:0] v);
        rd_latch = 1'b1; #2; v = rdata; rd_latch = 1'b0; #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] tmp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1", "pd_n after reset", pd_n, 8'hFF);
        chk("R1", "level after reset", lvl, 8'hFF);
        chk("R4", "no float in pull-up build", hiz, 8'h00);
        chk("R9", "open-drain floats after reset", od_hiz, 8'hFF);
        chk("R8", "idle read data", rdata, 8'h00);
        read_pin(v);
        chk("R1", "pin read after reset", v, 8'hFF);

        // table walk: R2 R3 R4 R5 R6 R7 R9
        for (int k = 0; k < NVEC; k++) begin
            ext_drive_en = VECS[k].en;
            ext_level    = VECS[k].ext;
            wr(VECS[k].wdata);
            #2;
            chk("R2", $sformatf("vec%0d pd_n", k), pd_n, VECS[k].wdata);
            chk("R5", $sformatf("vec%0d level", k), lvl, VECS[k].exp_lvl);
            chk("R9", $sformatf("vec%0d od hiz", k), od_hiz, VECS[k].exp_odhiz);
            tick();
            tick();
            read_pin(v);
            chk("R6", $sformatf("vec%0d pin read", k), v, VECS[k].exp_lvl);
            read_latch(v);
            chk("R7", $sformatf("vec%0d latch read", k), v, VECS[k].wdata);
        end

        // R3 pull-down beats an external high
        ext_drive_en = 8'hFF; ext_level = 8'hFF;
        wr(8'h00);
        #2;
        chk("R3", "sunk pins stay low", lvl, 8'h00);
        chk("R9", "sunk pins not floating", od_hiz, 8'h00);

        // R2 no write strobe: bus changes ignored
        bus_wdata = 8'h3C;
        tick(); tick();
        chk("R2", "latch holds without strobe", pd_n, 8'h00);

        // R6 latency: one edge old, two edges new
        ext_drive_en = 8'h00;
        wr(8'hFF);
        tick(); tick(); tick();
        ext_drive_en = 8'hFF; ext_level = 8'h00;
        tick();
        read_pin(v);
        chk("R6", "after one edge still old", v, 8'hFF);
        tick();
        read_pin(v);
        chk("R6", "after two edges new", v, 8'h00);

        // R7 latch differs from pin
        read_latch(v);
        chk("R7", "latch read while pins held low", v, 8'hFF);

        // R8 priority and idle
        rd_pin = 1'b1; rd_latch = 1'b1; #2;
        chk("R8", "both strobes give pin", rdata, 8'h00);
        rd_pin = 1'b0; rd_latch = 1'b0; #2;
        chk("R8", "no strobe gives zero", rdata, 8'h00);

        // R9 open-drain driven pins follow the source
        ext_drive_en = 8'h0F; ext_level = 8'h05;
        #2;
        chk("R9", "od hiz undriven half", od_hiz, 8'hF0);
        chk("R5", "od driven bits", od_lvl & 8'h0F, 8'h05);

        // R10 read-modify-write: clear bit7 while bit0 held low outside
        ext_drive_en = 8'h01; ext_level = 8'h00;
        tick(); tick(); tick();
        read_latch(tmp);
        wr(tmp & 8'h7F);
        read_latch(v);
        chk("R10", "bit0 survives RMW via latch", v, 8'h7F);
        tick(); tick();
        read_pin(v);
        chk("R10", "pin view of same port", v, 8'h7E);

        done = 1'b1;
        finish_run();
    end

endmodule